// File: doc/BRIEF.md
# Byte-Stream Serial Port Register Front-End

This block puts a simple serial port behind a 32-bit, word-addressed register bus. Software sees three registers: a transmit-data register that passes one byte to an outbound byte stream, a receive-data register holding the last byte taken from an inbound byte stream, and a read-only status word. Both streams use valid/ready handshakes. The serializer and the deserializer sit outside this block.

On the inbound side there is a single holding byte. Once a byte has been captured, the inbound ready is held low until software reads the receive-data register. A byte that arrives while that register is being read is left waiting, and it is captured in the following cycle. On the outbound side there is a single pending byte. It is offered on the stream until the stream takes it, and while it waits, further transmit writes are dropped.

All bus accesses are single-cycle. Read data is combinational during the access cycle, and side effects take place at the clock edge that ends it. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `byte_port_regs`

## Requirements
- R1: After reset, the status register reads 0x0000_0002, the receive-data register reads 0, `out_valid` is 0 and `in_ready` is 1.
- R2: In the status word, bit 0 is receive-ready (a byte is held) and bit 1 is transmit-ready (no byte pending). Bits 31:2 always read 0.
- R3: An inbound byte is captured when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low while receive-ready is set, so bytes offered during that time are not taken.
- R4: A full-word read at byte offset 0x04 returns the held byte in bits 7:0 and clears receive-ready at the end of the access. If receive-ready is already clear, the same read returns the last held byte and changes nothing.
- R5: During a read of offset 0x04, `in_ready` is low. A byte offered in that cycle is not captured; the read returns the old byte, and the new byte is captured in the next cycle if it is still offered.
- R6: A full-word write at offset 0x00 made while transmit-ready is set places bits 7:0 of the write data on `out_byte`, with `out_valid` high from the next cycle. Transmit-ready stays low until a cycle with `out_valid` and `out_ready` both high.
- R7: A transmit write made while transmit-ready is low is dropped. The pending byte stays on `out_byte`, and the dropped byte is never sent.
- R8: Writes to the status register at offset 0x14 change no bit and have no other effect.
- R9: Offsets 0x08, 0x0C and 0x10, and any offset at or above 0x18, are unimplemented. Reads there return 0, and writes there do nothing.
- R10: An access with `bus_be` other than 4'b1111, or with a byte address not aligned to 4, is invalid. Such a read returns 0 and has no side effect, and such a write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is valid |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| out_valid | output | 1 | Outbound byte pending |
| out_ready | input | 1 | Outbound sink takes the byte |
| out_byte | output | 8 | Outbound byte |
| in_valid | input | 1 | Inbound byte offered |
| in_ready | output | 1 | Block can capture an inbound byte |
| in_byte | input | 8 | Inbound byte |

## Verification
A wrong receive-ready flag is visible at the ports in the same cycle: `in_ready` and status bit 0 both come straight from it. A flag that was not cleared by a read therefore blocks the next byte on the first cycle it is offered. A flag that was not set lets a second byte overwrite the first, and the next read returns the wrong value. A stuck or early-cleared transmit flag shows on `out_valid` and status bit 1 one cycle after the write or the handshake. The scoreboard also catches bytes that are lost, duplicated or leaked from dropped writes when it matches every completed outbound transfer against the queue of accepted writes.

// File: rtl/bport_pkg.sv
package bport_pkg;
  localparam int BP_WIN_BYTES = 24;
  localparam int BP_IDX_TX    = 0;
  localparam int BP_IDX_RX    = 1;
  localparam int BP_IDX_ST    = 5;
  localparam int BP_ST_RXBIT  = 0;
  localparam int BP_ST_TXBIT  = 1;

  typedef struct packed {
    logic tx_wr;
    logic rx_rd;
    logic st_rd;
  } bp_acc_t;
endpackage

// File: rtl/bport_rstsync.sv
module bport_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bport_decode.sv
module bport_decode
  import bport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W/8-1:0]  be,
  output bp_acc_t             acc
);
  localparam int BE_W      = BUS_W / 8;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int WIN_WORDS = BP_WIN_BYTES / 4;

  logic [IDX_W-1:0] idx;
  logic             legal;

  always_comb begin
    idx   = addr[ADDR_W-1:2];
    legal = req && (be == {BE_W{1'b1}}) && (addr[1:0] == 2'b00)
            && (int'(idx) < WIN_WORDS);
    acc.tx_wr = legal &&  we && (idx == IDX_W'(BP_IDX_TX));
    acc.rx_rd = legal && !we && (idx == IDX_W'(BP_IDX_RX));
    acc.st_rd = legal && !we && (idx == IDX_W'(BP_IDX_ST));
  end
endmodule

// File: rtl/bport_rxhold.sv
module bport_rxhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              in_ready,
  output logic              full,
  output logic [DATA_W-1:0] held
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] held_q;
  logic              cap_en;

  always_comb begin
    in_ready = !full_q && !rd_strobe;
    cap_en   = in_valid && in_ready;
    full_d   = full_q;
    if (rd_strobe) full_d = 1'b0;
    if (cap_en)    full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else begin
      full_q <= full_d;
      if (cap_en) held_q <= in_byte;
    end
  end

  assign full = full_q;
  assign held = held_q;
endmodule

// File: rtl/bport_txhold.sv
module bport_txhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              busy
);
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] byte_q;
  logic              load_en, done;

  always_comb begin
    load_en = wr_strobe && !busy_q;
    done    = busy_q && out_ready;
    busy_d  = busy_q;
    if (done)    busy_d = 1'b0;
    if (load_en) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      byte_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (load_en) byte_q <= wr_byte;
    end
  end

  assign out_valid = busy_q;
  assign out_byte  = byte_q;
  assign busy      = busy_q;
endmodule

// File: rtl/byte_port_regs.sv
module byte_port_regs
  import bport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W/8-1:0] bus_be,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_byte,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_byte
);
  logic              rst_q_n;
  bp_acc_t           acc;
  logic              rx_full;
  logic [DATA_W-1:0] rx_held;
  logic              tx_busy;

  bport_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_q_n)
  );

  bport_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .be(bus_be), .acc(acc)
  );

  bport_rxhold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_q_n), .rd_strobe(acc.rx_rd),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .full(rx_full), .held(rx_held)
  );

  bport_txhold #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_q_n), .wr_strobe(acc.tx_wr),
    .wr_byte(bus_wdata[DATA_W-1:0]), .out_ready(out_ready),
    .out_valid(out_valid), .out_byte(out_byte), .busy(tx_busy)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc.rx_rd) begin
      bus_rdata[DATA_W-1:0] = rx_held;
    end else if (acc.st_rd) begin
      bus_rdata[BP_ST_RXBIT] = rx_full;
      bus_rdata[BP_ST_TXBIT] = !tx_busy;
    end
  end
endmodule

// File: rtl/bport_checker.sv
module bport_checker #(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BUS_W/8-1:0] bus_be,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_byte,
  input logic               in_valid,
  input logic               in_ready,
  input logic               rx_full
);
  logic full_rd, rd_rx, rd_st, rd_bad, rd_hole;

  always_comb begin
    full_rd = bus_req && !bus_we && (bus_be == {(BUS_W/8){1'b1}});
    rd_rx   = full_rd && (bus_addr == ADDR_W'(4));
    rd_st   = full_rd && (bus_addr == ADDR_W'(20));
    rd_bad  = bus_req && !bus_we && ((bus_be != {(BUS_W/8){1'b1}}) || (bus_addr[1:0] != 2'b00));
    rd_hole = full_rd && ((bus_addr == ADDR_W'(8)) || (bus_addr == ADDR_W'(12))
              || (bus_addr == ADDR_W'(16)) || (int'(bus_addr) >= 24));
  end

  a_r3_capture_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (rx_full && !in_ready));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_full) |=> !rx_full);

  a_r5_no_capture_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx |-> !in_ready);

  a_r6_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  a_r2_status_view: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |-> (bus_rdata == {{(BUS_W-2){1'b0}}, !out_valid, rx_full}));

  a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hole |-> (bus_rdata == '0));

  a_r10_bad_access_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> (bus_rdata == '0));
endmodule

bind byte_port_regs bport_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .in_valid(in_valid), .in_ready(in_ready), .rx_full(rx_full)
);

// File: tb/sim_byte_port_regs.sv
`timescale 1ns/1ps
module sim_byte_port_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [4:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        out_valid, out_ready;
  logic [7:0]  out_byte;
  logic        in_valid, in_ready;
  logic [7:0]  in_byte;

  logic        nxt_iv = 1'b0;
  logic [7:0]  nxt_ib = 8'h00;
  logic        nxt_ordy = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_exp_q[$];

  always #2 clk = ~clk;

  byte_port_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic we, input logic [4:0] a,
                      input logic [3:0] be, input logic [31:0] wd,
                      input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = rq; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    in_valid = nxt_iv; in_byte = nxt_ib; out_ready = nxt_ordy;
    if (rq && !we) begin
      rd_exp_q.push_back(exp);
      rd_tag_q.push_back(tag);
    end
  endtask

  task automatic nop();
    step(1'b0, 1'b0, 5'h00, 4'h0, 32'h0, 32'h0, "");
  endtask
  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    step(1'b1, 1'b0, a, 4'hF, 32'h0, exp, tag);
  endtask
  task automatic rdbe(input logic [4:0] a, input logic [3:0] be, input logic [31:0] exp, input string tag);
    step(1'b1, 1'b0, a, be, 32'h0, exp, tag);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, 4'hF, d, 32'h0, "");
  endtask
  task automatic wrbe(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    step(1'b1, 1'b1, a, be, d, 32'h0, "");
  endtask

  // Monitor: read data and completed outbound transfers against the queues
  always @(negedge clk) begin
    #1;
    if (rst_n && bus_req && !bus_we && rd_exp_q.size() > 0)
      chk(bus_rdata, rd_exp_q.pop_front(), rd_tag_q.pop_front());
    if (rst_n && out_valid && out_ready) begin
      if (tx_exp_q.size() == 0) chk({24'h0, out_byte}, 32'hFFFF_FFFF, "R7 unexpected outbound byte");
      else chk({24'h0, out_byte}, {24'h0, tx_exp_q.pop_front()}, "R6 outbound byte");
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    in_valid = 0; in_byte = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) nop();

    // R1 reset state
    nop(); #1;
    chk({31'h0, out_valid}, 32'h0, "R1 out_valid");
    chk({31'h0, in_ready}, 32'h1, "R1 in_ready");
    rd(5'h14, 32'h2, "R1 status");
    rd(5'h04, 32'h0, "R1 rx data");

    // R3 capture, then refusal while full
    nxt_iv = 1; nxt_ib = 8'hA5; nop();
    nxt_ib = 8'h11; nop(); #1;
    chk({31'h0, in_ready}, 32'h0, "R3 in_ready low when full");
    rd(5'h14, 32'h3, "R2 status both flags");
    nxt_iv = 0;
    rd(5'h04, 32'hA5, "R4 rx data");
    rd(5'h14, 32'h2, "R4 flag cleared");
    rd(5'h04, 32'hA5, "R4 reread last byte");
    rd(5'h14, 32'h2, "R4 status unchanged");

    // R5 arrival during a read
    nxt_iv = 1; nxt_ib = 8'h3C;
    rd(5'h04, 32'hA5, "R5 old byte"); #1;
    chk({31'h0, in_ready}, 32'h0, "R5 in_ready low during read");
    nop();
    nxt_ib = 8'h77;
    rd(5'h14, 32'h3, "R5 new byte held");
    rd(5'h04, 32'h3C, "R5 read while next offered");
    nop();
    nxt_iv = 0;
    rd(5'h14, 32'h3, "R5 deferred byte captured");
    rd(5'h04, 32'h77, "R5 deferred byte");
    rd(5'h14, 32'h2, "R5 status after");

    // R6 / R7 transmit
    nxt_ordy = 0;
    wr(5'h00, 32'h1234_56C3); tx_exp_q.push_back(8'hC3);
    nop(); #1;
    chk({31'h0, out_valid}, 32'h1, "R6 out_valid");
    chk({24'h0, out_byte}, 32'hC3, "R6 out_byte low bits");
    rd(5'h14, 32'h0, "R6 tx-ready low");
    wr(5'h00, 32'h0000_0099);
    nop(); #1;
    chk({24'h0, out_byte}, 32'hC3, "R7 pending byte kept");
    nxt_ordy = 1; nop();
    nxt_ordy = 0; nop(); #1;
    chk({31'h0, out_valid}, 32'h0, "R6 out_valid after handshake");
    rd(5'h14, 32'h2, "R6 tx-ready back");
    nxt_ordy = 1;
    wr(5'h00, 32'hFFFF_FF5A); tx_exp_q.push_back(8'h5A);
    nop(); nop(); #1;
    chk({31'h0, out_valid}, 32'h0, "R6 second byte sent");
    nxt_ordy = 0;

    // R8 status writes ignored
    nxt_iv = 1; nxt_ib = 8'h42; nop();
    nxt_iv = 0;
    wr(5'h14, 32'h0);
    rd(5'h14, 32'h3, "R8 write 0 ignored");
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, 32'h3, "R8 write ones ignored");
    rd(5'h04, 32'h42, "R8 rx intact");
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, 32'h2, "R8 no flag set");
    nop(); #1;
    chk({31'h0, out_valid}, 32'h0, "R8 no outbound");

    // R9 unimplemented offsets
    rd(5'h08, 32'h0, "R9 0x08");
    rd(5'h0C, 32'h0, "R9 0x0C");
    rd(5'h10, 32'h0, "R9 0x10");
    rd(5'h18, 32'h0, "R9 0x18");
    rd(5'h1C, 32'h0, "R9 0x1C");
    wr(5'h08, 32'h0000_00AB);
    wr(5'h18, 32'h0000_00CD);
    nop(); #1;
    chk({31'h0, out_valid}, 32'h0, "R9 write discarded");
    rd(5'h14, 32'h2, "R9 status unchanged");

    // R10 partial and misaligned accesses
    nxt_iv = 1; nxt_ib = 8'hE1; nop();
    nxt_iv = 0;
    rdbe(5'h04, 4'h3, 32'h0, "R10 partial rx read");
    rdbe(5'h14, 4'hE, 32'h0, "R10 partial status read");
    rd(5'h05, 32'h0, "R10 misaligned read");
    rd(5'h14, 32'h3, "R10 flag not cleared");
    wrbe(5'h00, 4'h1, 32'h0000_0066);
    nop(); #1;
    chk({31'h0, out_valid}, 32'h0, "R10 partial write discarded");
    rd(5'h04, 32'hE1, "R10 byte intact");
    nop(); nop();

    chk(tx_exp_q.size(), 32'h0, "R7 all accepted bytes sent");
    chk(rd_exp_q.size(), 32'h0, "R4 all reads compared");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule